// File: doc/BRIEF.md
# Predicated Data-Processing Execute Unit

This block decodes and executes one 32-bit data-processing instruction word per clock. It holds a sixteen-entry, 32-bit register file and a four-bit flag register (negative, zero, carry, overflow). Each accepted word names a first source register and a destination register. A second operand comes either from a register or from a rotated 8-bit immediate. A four-bit predicate is tested against the stored flags to decide whether the word runs at all.

Each accepted word has one of three outcomes. When the predicate holds, the unit computes one of sixteen operations. It writes the destination unless the operation is a compare or a test. It updates the flags only when the word's set-flags bit is 1. When the predicate fails, nothing changes and a one-cycle skip indication is raised. A result is registered in the clock edge that samples the word, so the next word in the following cycle already reads the updated register.

Top module: `cond_dp_exec`

## Requirements
- R1: Word fields: predicate [31:28], class bits [27:26], immediate select [25], opcode [24:21], set-flags [20], first source [19:16], destination [15:12], operand field [11:0]. With immediate select 0 the second operand is the register named by [3:0]. A word whose class bits are not 00 has no effect and raises no skip.
- R2: With immediate select 1 the second operand is [7:0] zero-extended and rotated right by twice the value in [11:8].
- R3: Opcodes 0100 ADD (a+b), 0010 SUB (a-b) and 0011 RSB (b-a) write their result to the destination register.
- R4: Opcodes 0000 AND, 0001 EOR, 1100 ORR, 1110 BIC (a AND NOT b), 1101 MOV (b) and 1111 MVN (NOT b) write their result. MVN of immediate 8 gives 0xFFFFFFF7.
- R5: 0101 ADC computes a+b+C. 0110 SBC computes a-b-1+C. 0111 RSC computes b-a-1+C. C is the stored carry flag.
- R6: 1000 TST (a AND b), 1001 TEQ (a XOR b), 1010 CMP (a-b) and 1011 CMN (a+b) never write a register. With set-flags 1 they update the flags.
- R7: With set-flags 0 the flag register keeps its value.
- R8: The flag register is {N,Z,C,V} in bits [3:0]. N is result bit 31 and Z marks a zero result. For additions C is the carry out, and for subtractions C is 1 when no borrow occurs. V marks signed overflow. Logical, move and test operations leave C and V unchanged.
- R9: Predicate codes: 0000 Z, 0001 !Z, 0010 C, 0011 !C, 0100 N, 0101 !N, 0110 V, 0111 !V, 1000 C&!Z, 1001 !C|Z, 1010 N==V, 1011 N!=V, 1100 !Z&(N==V), 1101 Z|(N!=V), 1110 always, 1111 never.
- R10: A word whose predicate fails changes neither registers nor flags, and skip is high in the following cycle.
- R11: Write port, flags and skip are valid in the cycle after the sampling edge. A word in the next cycle reads the new register value. With no valid word, write enable and skip are low.
- R12: Reset clears all registers and flags and drives write enable and skip low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Word present this cycle |
| instr_word | input | 32 | Instruction word |
| rf_we | output | 1 | Register write performed |
| rf_waddr | output | 4 | Written register index |
| rf_wdata | output | 32 | Written value |
| flags_nzcv | output | 4 | Flag register {N,Z,C,V} |
| skipped | output | 1 | Last word failed its predicate |

## Verification
Every result of this unit appears exactly one clock after the rising edge that samples the word. This covers the write port, the flag register and the skip line. The driver applies each word on a falling edge, so it is stable at the next rising edge. After that rising edge it pushes the model's expected outcome. The monitor pops and compares on the falling edge that follows, half a cycle after the registers have settled. Idle cycles push an idle expectation, so a stray write or skip is caught. Back-to-back dependent words check that a result is forwarded through the register file within one cycle.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int XLEN  = 32;
  localparam int RIDX  = 4;
  localparam int NREG  = 1 << RIDX;
  localparam int IMMW  = 8;
  localparam int ROTW  = 4;
  localparam int FLAGW = 4;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } dp_op_e;

  typedef struct packed {
    logic [XLEN-1:0]  res;
    logic [FLAGW-1:0] nzcv;
    logic             wr;
    logic             logic_cls;
  } alu_res_t;

  // rotate an 8-bit immediate right by twice the rotate field
  function automatic logic [XLEN-1:0] rot_imm(input logic [ROTW+IMMW-1:0] f);
    logic [XLEN-1:0] v;
    int unsigned     sh;
    v  = {{(XLEN-IMMW){1'b0}}, f[IMMW-1:0]};
    sh = 2 * int'(f[ROTW+IMMW-1:IMMW]);
    if (sh == 0) return v;
    return (v >> sh) | (v << (XLEN - sh));
  endfunction

  // predicate check; flags are {N,Z,C,V}
  function automatic logic cond_holds(input logic [3:0] c, input logic [FLAGW-1:0] f);
    logic n, z, cy, v, base;
    {n, z, cy, v} = f;
    case (c[3:1])
      3'd0: base = z;
      3'd1: base = cy;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = cy & ~z;
      3'd5: base = (n == v);
      3'd6: base = ~z & (n == v);
      default: base = 1'b1;
    endcase
    return c[0] ? ~base : base;
  endfunction
endpackage

// File: rtl/dp_cond_check.sv
module dp_cond_check
  import dp_pkg::*;
(
  input  logic [3:0]       cond,
  input  logic [FLAGW-1:0] nzcv,
  output logic             pass
);
  assign pass = cond_holds(cond, nzcv);
endmodule

// File: rtl/dp_op2_sel.sv
module dp_op2_sel
  import dp_pkg::*;
(
  input  logic                   imm_sel,
  input  logic [ROTW+IMMW-1:0]   field,
  input  logic [XLEN-1:0]        reg_val,
  output logic [XLEN-1:0]        op2
);
  assign op2 = imm_sel ? rot_imm(field) : reg_val;
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
(
  input  dp_op_e           op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [FLAGW-1:0] fin,
  output alu_res_t         out
);
  logic [XLEN-1:0] x, y, lres;
  logic            cin, arith;
  logic [XLEN:0]   sum;
  logic            vov;

  always_comb begin
    arith = 1'b1;
    x = a; y = b; cin = 1'b0;
    case (op)
      OP_SUB, OP_CMP: begin y = ~b; cin = 1'b1;   end
      OP_RSB:         begin x = b; y = ~a; cin = 1'b1; end
      OP_ADC:         cin = fin[1];
      OP_SBC:         begin y = ~b; cin = fin[1]; end
      OP_RSC:         begin x = b; y = ~a; cin = fin[1]; end
      OP_ADD, OP_CMN: cin = 1'b0;
      default:        arith = 1'b0;
    endcase
    sum = {1'b0, x} + {1'b0, y} + {{XLEN{1'b0}}, cin};
    vov = (x[XLEN-1] == y[XLEN-1]) && (sum[XLEN-1] != x[XLEN-1]);
    case (op)
      OP_AND, OP_TST: lres = a & b;
      OP_EOR, OP_TEQ: lres = a ^ b;
      OP_ORR:         lres = a | b;
      OP_MOV:         lres = b;
      OP_BIC:         lres = a & ~b;
      default:        lres = ~b;
    endcase
    out.res       = arith ? sum[XLEN-1:0] : lres;
    out.nzcv      = {out.res[XLEN-1], out.res == '0,
                     arith ? sum[XLEN] : fin[1],
                     arith ? vov       : fin[0]};
    out.wr        = (op[3:2] != 2'b10);
    out.logic_cls = ~arith;
  end
endmodule

// File: rtl/cond_dp_exec.sv
module cond_dp_exec
  import dp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  logic [XLEN-1:0]  instr_word,
  output logic             rf_we,
  output logic [RIDX-1:0]  rf_waddr,
  output logic [XLEN-1:0]  rf_wdata,
  output logic [FLAGW-1:0] flags_nzcv,
  output logic             skipped
);
  logic [XLEN-1:0] regs [NREG];

  logic [3:0]      cond;
  logic            is_dp, imm_sel, s_bit;
  dp_op_e          opc;
  logic [RIDX-1:0] rn, rd, rm;
  logic [11:0]     op2_field;
  logic [XLEN-1:0] a_val, m_val, b_val;
  logic            cond_pass, dp_valid, exec, is_test_class;
  alu_res_t        alu_o;

  assign cond      = instr_word[31:28];
  assign is_dp     = (instr_word[27:26] == 2'b00);
  assign imm_sel   = instr_word[25];
  assign opc       = dp_op_e'(instr_word[24:21]);
  assign s_bit     = instr_word[20];
  assign rn        = instr_word[19:16];
  assign rd        = instr_word[15:12];
  assign op2_field = instr_word[11:0];
  assign rm        = op2_field[RIDX-1:0];

  assign a_val = regs[rn];
  assign m_val = regs[rm];

  dp_cond_check u_cond (.cond(cond), .nzcv(flags_nzcv), .pass(cond_pass));
  dp_op2_sel    u_op2  (.imm_sel(imm_sel), .field(op2_field), .reg_val(m_val), .op2(b_val));
  dp_alu        u_alu  (.op(opc), .a(a_val), .b(b_val), .fin(flags_nzcv), .out(alu_o));

  assign dp_valid      = instr_valid && is_dp;
  assign exec          = dp_valid && cond_pass;
  assign is_test_class = (instr_word[24:23] == 2'b10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      flags_nzcv <= '0;
      rf_we      <= 1'b0;
      rf_waddr   <= '0;
      rf_wdata   <= '0;
      skipped    <= 1'b0;
    end else begin
      rf_we    <= exec && alu_o.wr;
      rf_waddr <= rd;
      rf_wdata <= alu_o.res;
      skipped  <= dp_valid && !cond_pass;
      if (exec && alu_o.wr) regs[rd] <= alu_o.res;
      if (exec && s_bit)    flags_nzcv <= alu_o.nzcv;
    end
  end

  // R10
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && !cond_pass) |=> (skipped && !rf_we && $stable(flags_nzcv)));
  // R6
  test_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && is_test_class) |=> !rf_we);
  // R7
  sbit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !s_bit) |=> $stable(flags_nzcv));
  // R9
  always_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && cond == 4'hE) |=> !skipped);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> (!rf_we && !skipped));
  // R8
  logic_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && s_bit && alu_o.logic_cls) |=> (flags_nzcv[1:0] == $past(flags_nzcv[1:0])));
  // R1
  nondp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !is_dp) |=> (!rf_we && !skipped && $stable(flags_nzcv)));
endmodule

// File: tb/sim_cond_dp_exec.sv
module sim_cond_dp_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic        rf_we;
  logic [3:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic [3:0]  flags_nzcv;
  logic        skipped;

  always #5 clk = ~clk;

  cond_dp_exec u0 (.clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
                   .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
                   .flags_nzcv(flags_nzcv), .skipped(skipped));

  typedef struct {
    logic        we; logic [3:0] addr; logic [31:0] data;
    logic [3:0]  fl; logic skip; string tag;
  } exp_t;
  exp_t exp_q[$];

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] m_regs [16];
  logic [3:0]  m_fl;

  function automatic logic [31:0] enc(input logic [3:0] c, input logic i, input logic [3:0] op,
                                      input logic s, input logic [3:0] rn, input logic [3:0] rd,
                                      input logic [11:0] o2);
    return {c, 2'b00, i, op, s, rn, rd, o2};
  endfunction

  function automatic logic pred(input logic [3:0] c, input logic [3:0] f);
    logic n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      4'h0: return z;           4'h1: return !z;
      4'h2: return cy;          4'h3: return !cy;
      4'h4: return n;           4'h5: return !n;
      4'h6: return v;           4'h7: return !v;
      4'h8: return cy && !z;    4'h9: return !cy || z;
      4'hA: return n == v;      4'hB: return n != v;
      4'hC: return !z && n == v; 4'hD: return z || n != v;
      4'hE: return 1'b1;        default: return 1'b0;
    endcase
  endfunction

  function automatic exp_t model(input logic [31:0] w, input string tag);
    exp_t e;
    logic [31:0] a, b, r; logic [3:0] op; logic cy, vv, arith;
    longint sa, sb, sr, ua, ub, ur;
    e.tag = tag; e.we = 0; e.skip = 0; e.addr = 4'h0; e.data = 32'h0;
    if (w[27:26] != 2'b00) begin e.fl = m_fl; return e; end
    if (!pred(w[31:28], m_fl)) begin e.skip = 1; e.fl = m_fl; return e; end
    a = m_regs[w[19:16]];
    if (w[25]) begin
      b = {24'h0, w[7:0]};
      for (int k = 0; k < 2 * int'(w[11:8]); k++) b = {b[0], b[31:1]};
    end else b = m_regs[w[3:0]];
    op = w[24:21]; cy = m_fl[1]; vv = m_fl[0]; arith = 1; r = 0;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    case (op)
      4'h4, 4'hB, 4'h5: begin
        ur = ua + ub + ((op == 4'h5) ? longint'(m_fl[1]) : 0);
        sr = sa + sb + ((op == 4'h5) ? longint'(m_fl[1]) : 0);
        cy = ur > 64'sh0FFFFFFFF;
      end
      4'h2, 4'hA, 4'h6: begin
        ur = ua - ub - ((op == 4'h6) ? longint'(!m_fl[1]) : 0);
        sr = sa - sb - ((op == 4'h6) ? longint'(!m_fl[1]) : 0);
        cy = ur >= 0;
      end
      4'h3, 4'h7: begin
        ur = ub - ua - ((op == 4'h7) ? longint'(!m_fl[1]) : 0);
        sr = sb - sa - ((op == 4'h7) ? longint'(!m_fl[1]) : 0);
        cy = ur >= 0;
      end
      default: begin arith = 0; ur = 0; sr = 0; end
    endcase
    if (arith) begin
      r = ur[31:0];
      vv = (sr > 64'sh7FFFFFFF) || (sr < -64'sh80000000);
    end else case (op)
      4'h0, 4'h8: r = a & b;
      4'h1, 4'h9: r = a ^ b;
      4'hC: r = a | b;
      4'hD: r = b;
      4'hE: r = a & ~b;
      default: r = ~b;
    endcase
    e.fl = w[20] ? {r[31], r == 32'h0, cy, vv} : m_fl;
    m_fl = e.fl;
    if (op < 4'h8 || op > 4'hB) begin
      e.we = 1; e.addr = w[15:12]; e.data = r; m_regs[w[15:12]] = r;
    end
    return e;
  endfunction

  task automatic issue(input logic [31:0] w, input string tag);
    exp_t e;
    @(negedge clk);
    instr_valid = 1'b1; instr_word = w;
    e = model(w, tag);
    @(posedge clk);
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    instr_valid = 1'b0;
    e.we = 0; e.addr = 0; e.data = 0; e.fl = m_fl; e.skip = 0; e.tag = tag;
    @(posedge clk);
    exp_q.push_back(e);
  endtask

  // monitor: compare half a cycle after the result edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      logic bad;
      e = exp_q.pop_front();
      n_cmp++;
      bad = (rf_we !== e.we) || (flags_nzcv !== e.fl) || (skipped !== e.skip) ||
            (e.we && ((rf_waddr !== e.addr) || (rf_wdata !== e.data)));
      if (bad) begin
        n_bad++;
        $display("FAIL %s: got we=%b a=%0d d=%h f=%b sk=%b, expected we=%b a=%0d d=%h f=%b sk=%b",
                 e.tag, rf_we, rf_waddr, rf_wdata, flags_nzcv, skipped,
                 e.we, e.addr, e.data, e.fl, e.skip);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got hang, expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) m_regs[i] = 32'h0;
    m_fl = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (rf_we !== 1'b0 || skipped !== 1'b0 || flags_nzcv !== 4'h0) begin
      n_bad++;
      $display("FAIL R12: got we=%b sk=%b f=%b, expected 0 0 0000", rf_we, skipped, flags_nzcv);
    end
    rst_n = 1'b1;
    // R12: registers cleared, so ADD R5,R6,R7 gives 0
    issue(enc(4'hE, 0, 4'h4, 0, 4'd6, 4'd5, 12'd7), "R12");
    issue(enc(4'hE, 1, 4'hD, 0, 4'd0, 4'd1, 12'h02A), "R4");      // MOV R1,#42
    issue(enc(4'hE, 1, 4'hD, 0, 4'd0, 4'd2, 12'h4FF), "R2");      // MOV R2,#0xFF ror 8
    issue(enc(4'hE, 1, 4'hD, 0, 4'd0, 4'd3, 12'h17F), "R2");      // #0x7F ror 2
    issue(enc(4'hE, 0, 4'h4, 0, 4'd1, 4'd0, 12'd2), "R3");        // ADD R0,R1,R2
    issue(enc(4'hE, 0, 4'h4, 0, 4'd0, 4'd4, 12'd1), "R11");       // back-to-back use of R0
    issue(enc(4'hE, 1, 4'hD, 0, 4'd0, 4'd3, 12'h47F), "R1");      // R3 = 0x7F000000
    issue(enc(4'hE, 0, 4'h4, 1, 4'd3, 4'd4, 12'd3), "R8");        // ADDS overflow -> N,V
    issue(enc(4'hE, 0, 4'h2, 1, 4'd1, 4'd5, 12'd1), "R8");        // SUBS equal -> Z,C
    issue(enc(4'h1, 1, 4'h4, 1, 4'd1, 4'd6, 12'h001), "R10");     // NE false -> skip
    issue(enc(4'h0, 1, 4'h4, 0, 4'd1, 4'd6, 12'h001), "R9");      // EQ true
    issue(enc(4'hF, 1, 4'hD, 1, 4'd0, 4'd7, 12'h001), "R9");      // never
    issue(enc(4'hE, 0, 4'hA, 1, 4'd1, 4'd9, 12'd2), "R6");        // CMP
    issue(enc(4'hE, 1, 4'h8, 1, 4'd1, 4'd9, 12'h008), "R6");      // TST bit3
    issue(enc(4'hE, 0, 4'h9, 1, 4'd1, 4'd9, 12'd1), "R6");        // TEQ equal
    issue(enc(4'hE, 1, 4'hB, 1, 4'd2, 4'd9, 12'h401), "R6");      // CMN carry out
    issue(enc(4'hE, 1, 4'hF, 0, 4'd0, 4'd8, 12'h008), "R4");      // MVN #8 -> -9
    issue(enc(4'hE, 1, 4'hE, 1, 4'd8, 4'd8, 12'h0FF), "R4");      // BICS, C/V kept
    issue(enc(4'hE, 0, 4'h0, 0, 4'd8, 4'd10, 12'd1), "R4");
    issue(enc(4'hE, 0, 4'h1, 0, 4'd8, 4'd10, 12'd2), "R4");
    issue(enc(4'hE, 0, 4'hC, 1, 4'd1, 4'd10, 12'd2), "R8");
    issue(enc(4'hE, 0, 4'h3, 1, 4'd2, 4'd11, 12'd1), "R3");       // RSBS
    issue(enc(4'hE, 0, 4'h2, 1, 4'd1, 4'd12, 12'd8), "R5");       // borrow, C=0
    issue(enc(4'hE, 0, 4'h6, 1, 4'd1, 4'd12, 12'd1), "R5");       // SBC with C=0
    issue(enc(4'hE, 0, 4'h5, 1, 4'd8, 4'd13, 12'd8), "R5");       // ADC
    issue(enc(4'hE, 0, 4'h7, 1, 4'd1, 4'd13, 12'd2), "R5");       // RSC
    issue(enc(4'hE, 1, 4'h4, 0, 4'd1, 4'd14, 12'h001), "R7");     // S=0 keeps flags
    issue({4'hE, 2'b01, 1'b1, 4'hD, 1'b1, 4'd0, 4'd1, 12'h000}, "R1");  // not a data-processing word
    idle("R11");
    issue(enc(4'hE, 0, 4'hD, 0, 4'd0, 4'd15, 12'd1), "R1");       // register-form MOV
    for (int k = 0; k < 400; k++) begin
      logic [31:0] w;
      logic [3:0] rr;
      rr = 4'($urandom);
      w = enc(4'($urandom), 1'($urandom), 4'($urandom), 1'($urandom), 4'($urandom),
              4'($urandom), 12'($urandom));
      if (!w[25]) w[11:0] = {8'h0, rr};
      issue(w, "R9");
      if (k % 37 == 0) idle("R11");
    end
    idle("R11");
    idle("R11");
    @(negedge clk);
    summary();
  end
endmodule